// File: doc/BRIEF.md
# Single-Channel DMA Transfer Controller

This block is a bus-master engine that moves a programmed amount of data between an I/O device and memory so the CPU does not have to copy it. Software loads a memory address and a byte count, then writes a control word that picks the device port, the direction, the unit size and the number of units per bus tenure. Setting the start bit in that same word launches the transfer.

Once started, the engine asks the system arbiter for the bus. When it is granted, it drives a request to the device with the memory address on the shared address lines. The device performs the memory access itself and answers with an acknowledge. Each acknowledge moves the address forward and the count down by one unit. When the count runs out, the engine drops the bus and raises a level interrupt. The interrupt stays high until software clears it. While the engine drives the device request, any CPU bus request is held off through a stall output. After each burst the engine gives the bus back for at least one cycle.

Top module: `dma_xfer_ctrl`

## Requirements
- R1: After reset `bus_req`, `dev_req`, `irq` and `cpu_stall` are low, and the address, count, control and status registers all read zero.
- R2: The register select picks 0 = memory address, 1 = byte count, 2 = control, 3 = status. The control bits are: bit 0 start, bit 1 direction (1 = memory to device), bit 2 unit (1 = word), bits 7:4 units per burst minus one, bits 11:8 device port, bit 16 done-clear. The control register reads back its stored fields with bits 0 and 16 as zero. In the status register, bit 0 is busy and bit 1 is done.
- R3: Writing control with bit 0 set, while idle and with a nonzero count, makes the engine busy and raises `bus_req` in the next cycle. `dev_req` stays low until a grant has been seen.
- R4: During every unit, `dev_req` is high, `bus_addr` carries the current memory address, and `dev_port`, `dev_dir` and `dev_word` carry the programmed fields. A unit completes on each clock edge at which `dev_ack` is high while `dev_req` is high.
- R5: Each completed unit adds 1 (byte unit) or WORD_BYTES (word unit) to the address and subtracts the same amount from the count, with the count saturating at zero. A count of C therefore takes ceil(C/step) units.
- R6: No more than (burst field + 1) units complete within one bus tenure. Between bursts `bus_req` is low for at least one cycle, so a transfer of N units raises `bus_req` ceil(N/B) times.
- R7: After the final unit, busy clears and `irq` rises. The address then reads start + N*step, the count reads 0, and status reads 2.
- R8: A start with a count of zero raises `irq` on the next cycle without ever requesting the bus.
- R9: `irq` holds until a control write with bit 16 set. A control write without that bit leaves `irq` unchanged.
- R10: While busy, writes to the address, count and control registers are ignored, and so is a second start.
- R11: `cpu_stall` equals `cpu_req` while `dev_req` is high, and is low otherwise.
- R12: `dev_req` is only ever high while `bus_gnt` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the selected register (combinational) |
| bus_req | output | 1 | Bus request to the system arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| cpu_req | input | 1 | CPU wants the bus |
| cpu_stall | output | 1 | CPU must wait: the engine owns the bus |
| dev_req | output | 1 | Unit request to the device |
| dev_port | output | PW | Selected device port |
| dev_dir | output | 1 | Direction, 1 = memory to device |
| dev_word | output | 1 | Unit size, 1 = word |
| bus_addr | output | AW | Memory address for the current unit (zero when idle) |
| dev_ack | input | 1 | Device reports the unit's memory access done |
| irq | output | 1 | Completion interrupt level |

## Verification
The bench goes after four kinds of mistake:
- Counts that are not a multiple of the word size. If the final step is not saturated, the count wraps and the transfer never ends.
- A one-unit burst field. If the release cycle is missing, the design holds the bus across bursts and the number of `bus_req` rises comes out low.
- Address wrap near the top of the space, and register writes plus a second start issued mid-transfer. A design that accepts these moves `bus_addr` away from the expected sequence or changes the number of units.
- A zero-count start, and control writes without the clear bit. Getting these wrong either touches the bus or drops the interrupt early.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_XFER, ST_GAP} dma_state_e;

  localparam logic [1:0] SEL_ADDR  = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_CTRL  = 2'd2;
  localparam logic [1:0] SEL_STAT  = 2'd3;

  localparam int CTL_START = 0;
  localparam int CTL_DIR   = 1;
  localparam int CTL_WORD  = 2;
  localparam int CTL_BURST = 4;
  localparam int CTL_PORT  = 8;
  localparam int CTL_CLEAR = 16;

  // bytes covered by one unit
  function automatic logic [31:0] unit_step(input logic word_unit, input int unsigned word_bytes);
    return word_unit ? 32'(word_bytes) : 32'd1;
  endfunction

  // true when the unit now in flight is the last one
  function automatic logic is_last_unit(input logic [31:0] remaining, input logic [31:0] step);
    return remaining <= step;
  endfunction

  // remaining bytes after one unit, saturating at zero
  function automatic logic [31:0] count_after(input logic [31:0] remaining, input logic [31:0] step);
    return (remaining > step) ? remaining - step : 32'd0;
  endfunction

endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int BW = 4,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic          busy,
  input  logic          unit_done,
  input  logic          finish,
  input  logic [31:0]   step,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] cur_count,
  output logic          ctl_dir,
  output logic          ctl_word,
  output logic [BW-1:0] ctl_burst,
  output logic [PW-1:0] ctl_port,
  output logic          irq,
  output logic          start_req,
  output logic          clear_req
);

  logic wr_ctrl, wr_addr, wr_count;

  assign wr_ctrl   = cfg_wr && (cfg_sel == SEL_CTRL);
  assign wr_addr   = cfg_wr && (cfg_sel == SEL_ADDR) && !busy;
  assign wr_count  = cfg_wr && (cfg_sel == SEL_COUNT) && !busy;
  assign start_req = wr_ctrl && cfg_wdata[CTL_START] && !busy;
  assign clear_req = wr_ctrl && cfg_wdata[CTL_CLEAR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr  <= '0;
      cur_count <= '0;
      ctl_dir   <= 1'b0;
      ctl_word  <= 1'b0;
      ctl_burst <= '0;
      ctl_port  <= '0;
      irq       <= 1'b0;
    end else begin
      if (unit_done) begin
        cur_addr  <= cur_addr + step[AW-1:0];
        cur_count <= CW'(count_after(32'(cur_count), step));
      end else begin
        if (wr_addr)  cur_addr  <= cfg_wdata[AW-1:0];
        if (wr_count) cur_count <= cfg_wdata[CW-1:0];
      end
      if (wr_ctrl && !busy) begin
        ctl_dir   <= cfg_wdata[CTL_DIR];
        ctl_word  <= cfg_wdata[CTL_WORD];
        ctl_burst <= cfg_wdata[CTL_BURST +: BW];
        ctl_port  <= cfg_wdata[CTL_PORT +: PW];
      end
      if (finish)         irq <= 1'b1;
      else if (clear_req) irq <= 1'b0;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_sel)
      SEL_ADDR:  cfg_rdata = 32'(cur_addr);
      SEL_COUNT: cfg_rdata = 32'(cur_count);
      SEL_CTRL: begin
        cfg_rdata[CTL_DIR]            = ctl_dir;
        cfg_rdata[CTL_WORD]           = ctl_word;
        cfg_rdata[CTL_BURST +: BW]    = ctl_burst;
        cfg_rdata[CTL_PORT +: PW]     = ctl_port;
      end
      default: cfg_rdata[1:0] = {irq, busy};
    endcase
  end

endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int CW = 16,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_req,
  input  logic [CW-1:0] cur_count,
  input  logic [31:0]   step,
  input  logic [BW-1:0] burst_m1,
  input  logic          bus_gnt,
  input  logic          dev_ack,
  output logic          bus_req,
  output logic          dev_req,
  output logic          busy,
  output logic          unit_done,
  output logic          burst_end,
  output logic          finish
);

  dma_state_e    state;
  logic [BW-1:0] beat;
  logic          last;

  assign last      = is_last_unit(32'(cur_count), step);
  assign unit_done = (state == ST_XFER) && dev_ack;
  assign burst_end = unit_done && !last && (beat == burst_m1);
  assign finish    = (unit_done && last) || (start_req && (cur_count == '0));
  assign bus_req   = (state == ST_REQ) || (state == ST_XFER);
  assign dev_req   = (state == ST_XFER);
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      beat  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          beat <= '0;
          if (start_req && (cur_count != '0)) state <= ST_REQ;
        end
        ST_REQ: if (bus_gnt) state <= ST_XFER;
        ST_XFER: if (unit_done) begin
          if (last) begin
            state <= ST_IDLE;
          end else if (burst_end) begin
            state <= ST_GAP;
            beat  <= '0;
          end else begin
            beat  <= beat + 1'b1;
          end
        end
        default: state <= ST_REQ;
      endcase
    end
  end

endmodule

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl
  import dma_pkg::*;
#(
  parameter int AW         = 32,
  parameter int CW         = 16,
  parameter int WORD_BYTES = 4,
  parameter int BW         = 4,
  parameter int PW         = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  output logic          bus_req,
  input  logic          bus_gnt,
  input  logic          cpu_req,
  output logic          cpu_stall,
  output logic          dev_req,
  output logic [PW-1:0] dev_port,
  output logic          dev_dir,
  output logic          dev_word,
  output logic [AW-1:0] bus_addr,
  input  logic          dev_ack,
  output logic          irq
);

  logic [AW-1:0] cur_addr;
  logic [CW-1:0] cur_count;
  logic [BW-1:0] ctl_burst;
  logic [31:0]   step_bytes;
  logic          busy, unit_done, burst_end, finish, start_req, clear_req;

  assign step_bytes = unit_step(dev_word, WORD_BYTES);

  dma_regs #(.AW(AW), .CW(CW), .BW(BW), .PW(PW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .busy      (busy),
    .unit_done (unit_done),
    .finish    (finish),
    .step      (step_bytes),
    .cur_addr  (cur_addr),
    .cur_count (cur_count),
    .ctl_dir   (dev_dir),
    .ctl_word  (dev_word),
    .ctl_burst (ctl_burst),
    .ctl_port  (dev_port),
    .irq       (irq),
    .start_req (start_req),
    .clear_req (clear_req)
  );

  dma_engine #(.CW(CW), .BW(BW)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .cur_count (cur_count),
    .step      (step_bytes),
    .burst_m1  (ctl_burst),
    .bus_gnt   (bus_gnt),
    .dev_ack   (dev_ack),
    .bus_req   (bus_req),
    .dev_req   (dev_req),
    .busy      (busy),
    .unit_done (unit_done),
    .burst_end (burst_end),
    .finish    (finish)
  );

  assign bus_addr  = dev_req ? cur_addr : '0;
  assign cpu_stall = cpu_req && dev_req;

endmodule

// File: rtl/dma_xfer_ctrl_chk.sv
module dma_xfer_ctrl_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          cpu_req,
  input logic          cpu_stall,
  input logic          dev_req,
  input logic          irq,
  input logic          busy,
  input logic          unit_done,
  input logic          burst_end,
  input logic          finish,
  input logic          clear_req,
  input logic [AW-1:0] cur_addr,
  input logic [31:0]   step_bytes,
  input logic          cfg_wr,
  input logic [1:0]    cfg_sel
);

  // R12
  req_needs_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_req |-> bus_gnt);

  // R11
  stall_while_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && dev_req) |-> cpu_stall);

  // R11
  no_stall_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |-> !cpu_stall);

  // R6
  burst_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_end |=> !bus_req);

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unit_done |=> cur_addr == $past(cur_addr) + $past(step_bytes[AW-1:0]));

  // R10
  busy_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_wr && (cfg_sel == 2'd0) && !unit_done) |=> cur_addr == $past(cur_addr));

  // R7
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(finish));

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clear_req) |=> irq);

endmodule

bind dma_xfer_ctrl dma_xfer_ctrl_chk #(.AW(AW)) u_chk (.*);

// File: tb/dma_xfer_ctrl_tb.sv
`timescale 1ns/1ps
module dma_xfer_ctrl_tb;

  localparam int AW = 32;
  localparam int WB = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        bus_req, cpu_stall, dev_req, dev_dir, dev_word, irq;
  logic        bus_gnt = 1'b0, cpu_req = 1'b0, dev_ack = 1'b0;
  logic [3:0]  dev_port;
  logic [AW-1:0] bus_addr;

  always #2 clk = ~clk;

  dma_xfer_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .cpu_req(cpu_req), .cpu_stall(cpu_stall),
    .dev_req(dev_req), .dev_port(dev_port), .dev_dir(dev_dir),
    .dev_word(dev_word), .bus_addr(bus_addr), .dev_ack(dev_ack), .irq(irq)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  // expectations shared with the device model
  logic [31:0] exp_addr = '0, exp_step = 32'd1;
  logic [3:0]  exp_port = '0;
  logic        exp_dir = 1'b0, exp_word = 1'b0;
  int          units = 0, rises = 0;
  logic        prev_req = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] units_for(input logic [31:0] cnt, input logic [31:0] s);
    return (cnt + s - 1) / s;
  endfunction

  // arbiter, device and CPU model, plus per-unit checks
  always @(negedge clk) begin
    if (!rst_n) begin
      bus_gnt = 1'b0; dev_ack = 1'b0; cpu_req = 1'b0;
    end else begin
      if (dev_req || cpu_stall) chk("R11 cpu stall", cpu_stall, cpu_req && dev_req);
      if (bus_req && !prev_req) rises++;
      prev_req = bus_req;
      if (!bus_req) bus_gnt = 1'b0;
      else if (!bus_gnt) bus_gnt = ($urandom % 2) == 0;
      dev_ack = dev_req && (($urandom % 3) != 0);
      cpu_req = ($urandom % 2) == 0;
      if (dev_req && dev_ack) begin
        chk("R12 grant during unit", bus_gnt, 1);
        chk("R4 unit address", bus_addr, exp_addr);
        chk("R4 unit attributes", {dev_port, dev_dir, dev_word}, {exp_port, exp_dir, exp_word});
        exp_addr = exp_addr + exp_step;
        units++;
      end
    end
  end

  task automatic reg_write(input logic [1:0] sel, input logic [31:0] d);
    cfg_sel = sel; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] sel, output logic [31:0] d);
    cfg_sel = sel;
    #1;
    d = cfg_rdata;
  endtask

  task automatic wait_idle(output bit ok);
    logic [31:0] st;
    int n;
    n = 0;
    do begin
      @(negedge clk);
      reg_read(2'd3, st);
      n++;
    end while (st[0] && n < 5000);
    ok = !st[0];
  endtask

  task automatic run_xfer(input logic [31:0] addr, input logic [31:0] cnt, input logic word,
                          input logic [3:0] bm1, input logic [3:0] port, input logic dir,
                          input bit poke);
    logic [31:0] s, n, ctrl, rd;
    bit ok;
    reg_write(2'd0, addr);
    reg_write(2'd1, cnt);
    s = word ? WB : 1;
    n = units_for(cnt, s);
    exp_addr = addr; exp_step = s; units = 0; rises = 0;
    exp_port = port; exp_dir = dir; exp_word = word;
    ctrl = (32'(port) << 8) | (32'(bm1) << 4) | (32'(word) << 2) | (32'(dir) << 1);
    reg_write(2'd2, ctrl | 32'h1);
    chk("R3 bus request after start", bus_req, 1);
    chk("R3 no device request before grant", dev_req, 0);
    reg_read(2'd3, rd);
    chk("R3 busy after start", rd[0], 1);
    if (poke) begin
      reg_write(2'd0, 32'hDEAD_BEE0);
      reg_write(2'd1, 32'h3);
      reg_write(2'd2, ctrl ^ 32'h0000_0F05);
    end
    wait_idle(ok);
    chk("R7 transfer finished", ok, 1);
    chk("R5 unit count", units, n);
    chk("R6 bus tenures", rises, (n + bm1) / (32'(bm1) + 1));
    reg_read(2'd0, rd); chk("R7 final address", rd, addr + n * s);
    reg_read(2'd1, rd); chk("R7 final count", rd, 0);
    reg_read(2'd2, rd); chk("R2 control readback", rd, ctrl);
    if (poke) chk("R10 control kept while busy", rd, ctrl);
    reg_read(2'd3, rd); chk("R7 status done", rd, 32'd2);
    chk("R7 irq raised", irq, 1);
    repeat (3) @(negedge clk);
    chk("R9 irq held", irq, 1);
    reg_write(2'd2, ctrl);
    chk("R9 irq kept without clear bit", irq, 1);
    reg_write(2'd2, 32'h0001_0000);
    chk("R9 irq cleared", irq, 0);
  endtask

  initial begin
    logic [31:0] rd;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk("R1 bus_req in reset", bus_req, 0);
    chk("R1 dev_req in reset", dev_req, 0);
    chk("R1 irq in reset", irq, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cpu_stall after reset", cpu_stall, 0);
    for (int i = 0; i < 4; i++) begin
      reg_read(2'(i), rd);
      chk("R1 register after reset", rd, 0);
    end

    run_xfer(32'h0000_1000, 5, 1'b0, 4'd0, 4'd3, 1'b0, 0);   // one unit per burst
    run_xfer(32'h0000_2000, 7, 1'b1, 4'd1, 4'd5, 1'b1, 0);   // partial last word
    run_xfer(32'hFFFF_FFF8, 16, 1'b1, 4'd15, 4'd9, 1'b0, 0); // address wraps
    run_xfer(32'h0000_0300, 60, 1'b0, 4'd2, 4'd1, 1'b0, 1);  // writes while busy
    run_xfer(32'h0000_0040, 1, 1'b0, 4'd7, 4'd0, 1'b1, 0);   // single byte

    // R8 zero-count start
    reg_write(2'd1, 32'd0);
    prev_req = 1'b0; rises = 0;
    reg_write(2'd2, 32'h1);
    chk("R8 irq on zero count", irq, 1);
    chk("R8 no bus request", bus_req, 0);
    reg_read(2'd3, rd);
    chk("R8 status on zero count", rd, 32'd2);
    repeat (3) @(negedge clk);
    chk("R8 bus never requested", rises, 0);
    reg_write(2'd2, 32'h0001_0000);
    chk("R9 irq cleared after zero count", irq, 0);

    for (int k = 0; k < 12; k++) begin
      run_xfer($urandom, ($urandom % 64) + 1, 1'($urandom % 2), 4'($urandom % 16),
               4'($urandom % 16), 1'($urandom % 2), ($urandom % 4) == 0);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL R7 watchdog: actual 0x0 expected 0x1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule